// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control of a successive-approximation ADC. It advances only on cycles where the ADC clock enable `adc_tick` is high. Each such cycle counts as one conversion cycle. A small register file holds the control word, the channel select and the two halves of the 10-bit result. Software starts a conversion by writing the control word. The sequencer then latches the channel, pulses the sample/hold strobe and walks a trial code from the most significant bit down, keeping each bit the comparator accepts. It then stores the result and raises a completion flag, which becomes a wake-up interrupt request when the interrupt enable is set.

The first conversion after the block is switched on runs on a longer schedule. It samples at conversion cycle 14, stores its result at cycle 26 and finishes at cycle 28. Later conversions sample at cycle 1, store at cycle 13 and finish at cycle 15. If the block is off and software switches it on and starts it in one write, the first pass is a dummy conversion whose outcome is thrown away. A valid conversion on the short schedule follows it without further action from software. This supports starting a conversion just before the core goes idle.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset all four registers read 0x00, `irq` is 0, `hold_strobe` is 0, and the block is off.
- R2: Register address 1 (channel) keeps only write bits 2:0; its bits 7:3 always read 0.
- R3: A conversion started while the long schedule is pending (after reset or after a switch-off) pulses `hold_strobe` after tick 14, sets the flag after tick 26, and clears the busy bit after tick 28, counting ticks from the start write.
- R4: Any later conversion pulses `hold_strobe` after tick 1, sets the flag after tick 13, and clears the busy bit after tick 15.
- R5: A control write with enable=1 and start=1 while the block is off runs a dummy conversion on the long schedule. The dummy sets no flag and leaves the result unchanged. A short-schedule valid conversion follows it, so the flag rises at tick 41 and busy clears at tick 43.
- R6: `hold_strobe` is a single clock pulse. The first trial code after it is 0x200, and bits are decided from bit 9 down to bit 0. A bit is kept when `comp_in` is 1.
- R7: On valid completion the 10-bit result appears with bits 9:8 at address 2 bits 1:0 and bits 7:0 at address 3. The result changes at no other time.
- R8: Control register address 0 has this layout: bit 7 enable, bit 6 start/busy, bit 4 completion flag, bit 3 interrupt enable, and the other bits read 0. The busy bit reads 1 from the start write until the valid conversion ends. A start written while busy is ignored.
- R9: Writing 1 to flag bit 4 clears the flag. If the flag is set in the same cycle, the set wins. `irq` is high when both the flag and the interrupt enable are set.
- R10: Writing enable=0 aborts a running conversion at once, with no flag and no result. The next conversion uses the long schedule.
- R11: The channel is latched from the channel register at the sample point. A channel write after sampling affects only the next conversion, and `ch_sel` holds steady until the next sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_tick | input | 1 | ADC clock enable; one conversion cycle per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 channel) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 channel, 2 result high, 3 result low) |
| rd_data | output | 8 | Read data, combinational |
| comp_in | input | 1 | Comparator: 1 when the held input is at or above the trial code |
| ch_sel | output | 3 | Latched analog channel select |
| hold_strobe | output | 1 | Sample/hold pulse |
| trial | output | 10 | Trial code driven to the DAC |
| irq | output | 1 | Completion interrupt / wake-up request |

## Verification
The completion flag can be set by the sequencer and cleared by a write-one-to-clear in the same clock. The bench provokes this by running a short conversion for twelve ticks. It then issues the thirteenth tick in the same cycle as a control write with the flag bit set, and requires `irq` to stay high afterwards. The clear on its own is checked right after with a plain write. A second overlap is also covered: a channel write and a repeated start land mid-conversion. Here the result must still come from the channel latched at the sample point, and the busy window must end at tick 15.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CHAN = 2'd1,
    A_RESH = 2'd2,
    A_RESL = 2'd3
  } reg_addr_e;

  // control word bit positions (software-visible layout)
  localparam int CB_EN   = 7;
  localparam int CB_GO   = 6;
  localparam int CB_FLAG = 4;
  localparam int CB_IE   = 3;
endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int RES_W        = 10,
  parameter int FIRST_SAMPLE = 14,
  parameter int FIRST_TOTAL  = 28,
  parameter int NORM_SAMPLE  = 1,
  parameter int NORM_TOTAL   = 15,
  parameter int READY_LAG    = 12,
  parameter int IDX_W        = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic             long_sched,
  output logic             ev_sample,
  output logic             ev_bit,
  output logic             ev_ready,
  output logic             ev_end,
  output logic             bit_win,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int CNT_W = $clog2(FIRST_TOTAL + RES_W + READY_LAG + 1);

  logic [CNT_W-1:0] cnt, nxt, samp, tot, diff;

  function automatic logic [CNT_W-1:0] pick(input logic sel, input int a, input int b);
    return sel ? CNT_W'(a) : CNT_W'(b);
  endfunction

  assign samp = pick(long_sched, FIRST_SAMPLE, NORM_SAMPLE);
  assign tot  = pick(long_sched, FIRST_TOTAL, NORM_TOTAL);
  assign nxt  = cnt + CNT_W'(1);
  assign diff = cnt - samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= '0;
    else if (run && tick) cnt <= nxt;
  end

  assign ev_sample = run && tick && (nxt == samp);
  assign ev_bit    = run && tick && (nxt > samp) && (nxt <= samp + CNT_W'(RES_W));
  assign ev_ready  = run && tick && (nxt == samp + CNT_W'(READY_LAG));
  assign ev_end    = run && tick && (nxt == tot);
  assign bit_win   = run && (cnt >= samp) && (cnt < samp + CNT_W'(RES_W));
  assign bit_idx   = IDX_W'(RES_W - 1) - IDX_W'(diff);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES_W = 10,
  parameter int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             win,
  input  logic [IDX_W-1:0] idx,
  input  logic             comp,
  output logic [RES_W-1:0] sar,
  output logic [RES_W-1:0] trial
);
  function automatic logic [RES_W-1:0] trial_word(
    input logic [RES_W-1:0] acc, input logic [IDX_W-1:0] k, input logic en);
    logic [RES_W-1:0] probe;
    probe = en ? (RES_W'(1) << k) : '0;
    return acc | probe;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sar <= '0;
    else if (clr)  sar <= '0;
    else if (load) sar[idx] <= comp;
  end

  assign trial = trial_word(sar, idx, win);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W        = 10,
  parameter int REG_W        = 8,
  parameter int CH_W         = 3,
  parameter int FIRST_SAMPLE = 14,
  parameter int FIRST_TOTAL  = 28,
  parameter int NORM_SAMPLE  = 1,
  parameter int NORM_TOTAL   = 15,
  parameter int READY_LAG    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             comp_in,
  output logic [CH_W-1:0]  ch_sel,
  output logic             hold_strobe,
  output logic [RES_W-1:0] trial,
  output logic             irq
);
  localparam int IDX_W = $clog2(RES_W);

  logic en_q, busy_q, dummy_q, long_q, flag_q, ie_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] res_q, sar;
  logic             wr_ctrl, launch, abort, restart;
  logic             ev_sample, ev_bit, ev_ready, ev_end, bit_win;
  logic [IDX_W-1:0] bit_idx;
  logic             unused_wd;

  assign unused_wd = wr_data[5];
  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign abort     = wr_ctrl && !wr_data[CB_EN];
  assign launch    = wr_ctrl && wr_data[CB_EN] && wr_data[CB_GO] && !busy_q;
  assign restart   = launch || abort || (ev_end && dummy_q);

  sar_timer #(
    .RES_W(RES_W), .FIRST_SAMPLE(FIRST_SAMPLE), .FIRST_TOTAL(FIRST_TOTAL),
    .NORM_SAMPLE(NORM_SAMPLE), .NORM_TOTAL(NORM_TOTAL), .READY_LAG(READY_LAG),
    .IDX_W(IDX_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(adc_tick), .run(busy_q), .restart(restart),
    .long_sched(long_q), .ev_sample(ev_sample), .ev_bit(ev_bit),
    .ev_ready(ev_ready), .ev_end(ev_end), .bit_win(bit_win), .bit_idx(bit_idx)
  );

  sar_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(ev_sample), .load(ev_bit), .win(bit_win),
    .idx(bit_idx), .comp(comp_in), .sar(sar), .trial(trial)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; busy_q <= 1'b0; dummy_q <= 1'b0; long_q <= 1'b1;
      flag_q <= 1'b0; ie_q <= 1'b0; chan_q <= '0; ch_sel <= '0;
      res_q <= '0; hold_strobe <= 1'b0;
    end else begin
      hold_strobe <= ev_sample;
      if (wr_ctrl) begin
        en_q <= wr_data[CB_EN];
        ie_q <= wr_data[CB_IE];
      end
      if (wr_en && (wr_addr == A_CHAN)) chan_q <= wr_data[CH_W-1:0];
      if (ev_sample) ch_sel <= chan_q;

      if (abort) begin
        busy_q <= 1'b0; dummy_q <= 1'b0; long_q <= 1'b1;
      end else if (launch) begin
        busy_q <= 1'b1; dummy_q <= !en_q;
      end else if (ev_end) begin
        long_q  <= 1'b0;
        dummy_q <= 1'b0;
        if (!dummy_q) busy_q <= 1'b0;
      end

      if (ev_ready && !dummy_q && !abort) begin
        flag_q <= 1'b1;
        res_q  <= sar;
      end else if (wr_ctrl && wr_data[CB_FLAG]) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL: begin
        rd_data[CB_EN]   = en_q;
        rd_data[CB_GO]   = busy_q;
        rd_data[CB_FLAG] = flag_q;
        rd_data[CB_IE]   = ie_q;
      end
      A_CHAN:  rd_data[CH_W-1:0] = chan_q;
      A_RESH:  rd_data = REG_W'(res_q >> REG_W);
      default: rd_data = res_q[REG_W-1:0];
    endcase
  end

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             busy,
  input logic             dummy,
  input logic             flag,
  input logic             abort,
  input logic             ev_sample,
  input logic             ev_ready,
  input logic             ev_end,
  input logic [RES_W-1:0] trial,
  input logic [RES_W-1:0] sar,
  input logic [RES_W-1:0] result,
  input logic [CH_W-1:0]  ch_sel
);
  a_r6_hold_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);

  a_r6_single_probe: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0(trial ^ sar));

  // R9: a completing valid conversion leaves the flag set, whatever is written
  a_r9_flag_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready && !dummy && !abort) |=> flag);

  a_r5_dummy_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready && dummy) |=> $stable(result));

  a_r8_end_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end && !dummy && !abort) |=> !busy);

  a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !dummy));

  a_r11_chan_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sample |=> $stable(ch_sel));
endmodule

bind sar_conv_seq sar_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold_strobe), .busy(busy_q), .dummy(dummy_q),
  .flag(flag_q), .abort(abort), .ev_sample(ev_sample), .ev_ready(ev_ready),
  .ev_end(ev_end), .trial(trial), .sar(sar), .result(res_q), .ch_sel(ch_sel)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       comp_in;
  logic [2:0] ch_sel;
  logic       hold_strobe;
  logic [9:0] trial;
  logic       irq;

  logic [9:0] vin [8];
  int n_chk = 0, n_bad = 0;
  int tk, hold_at, flag_at, end_at;
  bit done = 0;

  always #4 clk = ~clk;

  sar_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .comp_in(comp_in), .ch_sel(ch_sel), .hold_strobe(hold_strobe),
    .trial(trial), .irq(irq)
  );

  // comparator model: held input at or above the trial code
  assign comp_in = (trial <= vin[ch_sel]);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    adc_tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    adc_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1;
    v = int'(rd_data);
    rd_addr = 2'd0; #1;
  endtask

  task automatic clear_watch();
    tk = 0; hold_at = -1; flag_at = -1; end_at = -1;
  endtask

  task automatic watch();
    int c;
    if (hold_strobe && hold_at < 0) begin
      hold_at = tk;
      chk("R6 first trial after hold", int'(trial), 'h200);
    end
    if (irq && flag_at < 0) flag_at = tk;
    rd(2'd0, c);
    if (!c[6] && end_at < 0) end_at = tk;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) cyc(1'b0, 1'b0, 2'd0, 8'h00);
      cyc(1'b1, 1'b0, 2'd0, 8'h00);
      tk++;
      watch();
    end
  endtask

  task automatic result(output int v);
    int h, l;
    rd(2'd2, h); rd(2'd3, l);
    v = (h << 8) | l;
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset hold", int'(hold_strobe), 0);
  endtask

  task automatic t_chan_reg();
    int v;
    cyc(1'b0, 1'b1, 2'd1, 8'hFD);
    rd(2'd1, v);
    chk("R2 reserved channel bits", v, 'h05);
  endtask

  task automatic t_first();
    int v;
    cyc(1'b0, 1'b1, 2'd0, 8'h88);
    rd(2'd0, v);
    chk("R8 control readback", v, 'h88);
    clear_watch();
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    rd(2'd0, v);
    chk("R8 busy after start", (v >> 6) & 1, 1);
    run_ticks(30);
    chk("R3 first sample tick", hold_at, 14);
    chk("R3 first ready tick", flag_at, 26);
    chk("R3 first end tick", end_at, 28);
    result(v);
    chk("R7 result channel 5", v, int'(vin[5]));
    chk("R11 ch_sel latched", int'(ch_sel), 5);
    cyc(1'b0, 1'b1, 2'd0, 8'h98);
    chk("R9 W1C clears flag", int'(irq), 0);
  endtask

  task automatic t_normal();
    int v;
    cyc(1'b0, 1'b1, 2'd1, 8'h02);
    clear_watch();
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    run_ticks(3);
    cyc(1'b0, 1'b1, 2'd1, 8'h00);
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    run_ticks(14);
    chk("R4 normal sample tick", hold_at, 1);
    chk("R4 normal ready tick", flag_at, 13);
    chk("R8 end ignores restart", end_at, 15);
    result(v);
    chk("R11 result from latched channel", v, int'(vin[2]));
    chk("R11 ch_sel unchanged", int'(ch_sel), 2);
    cyc(1'b0, 1'b1, 2'd0, 8'h98);
  endtask

  task automatic t_collide();
    int v;
    clear_watch();
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    run_ticks(12);
    chk("R9 no flag before tick 13", int'(irq), 0);
    cyc(1'b1, 1'b1, 2'd0, 8'h98);
    tk++;
    chk("R9 set wins over clear", int'(irq), 1);
    result(v);
    chk("R7 result channel 0", v, int'(vin[0]));
    run_ticks(2);
    chk("R4 end after collision", end_at, 15);
    cyc(1'b0, 1'b1, 2'd0, 8'h98);
    chk("R9 plain clear", int'(irq), 0);
  endtask

  task automatic t_abort();
    int v;
    cyc(1'b0, 1'b1, 2'd1, 8'h03);
    clear_watch();
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    run_ticks(5);
    cyc(1'b0, 1'b1, 2'd0, 8'h08);
    rd(2'd0, v);
    chk("R10 abort clears busy", (v >> 6) & 1, 0);
    run_ticks(20);
    chk("R10 no flag after abort", flag_at, -1);
    result(v);
    chk("R7 result kept on abort", v, int'(vin[0]));
    cyc(1'b0, 1'b1, 2'd0, 8'h88);
    clear_watch();
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    run_ticks(30);
    chk("R10 long sample after re-enable", hold_at, 14);
    chk("R10 long ready after re-enable", flag_at, 26);
    chk("R10 long end after re-enable", end_at, 28);
    result(v);
    chk("R7 result channel 3", v, int'(vin[3]));
    cyc(1'b0, 1'b1, 2'd0, 8'h98);
  endtask

  task automatic t_dummy();
    int v;
    cyc(1'b0, 1'b1, 2'd1, 8'h07);
    cyc(1'b0, 1'b1, 2'd0, 8'h08);
    clear_watch();
    cyc(1'b0, 1'b1, 2'd0, 8'hC8);
    run_ticks(30);
    chk("R5 dummy sets no flag", flag_at, -1);
    result(v);
    chk("R5 dummy keeps result", v, int'(vin[3]));
    rd(2'd0, v);
    chk("R5 busy through dummy", (v >> 6) & 1, 1);
    run_ticks(15);
    chk("R5 dummy sample tick", hold_at, 14);
    chk("R5 valid ready tick", flag_at, 41);
    chk("R5 valid end tick", end_at, 43);
    result(v);
    chk("R5 valid result channel 7", v, int'(vin[7]));
  endtask

  initial begin
    vin[0] = 10'h000; vin[1] = 10'h001; vin[2] = 10'h3FF; vin[3] = 10'h155;
    vin[4] = 10'h0F0; vin[5] = 10'h2A5; vin[6] = 10'h0AA; vin[7] = 10'h301;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_chan_reg();
    t_first();
    t_normal();
    t_collide();
    t_abort();
    t_dummy();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule